// File: doc/BRIEF.md
# SAR conversion and calibration sequencer

This block is the clocked control core of a self-calibrating 12-bit successive-approximation converter that has a four-channel input multiplexer. A conversion can be started in one of two ways. The first is the rising edge of an active-low write strobe while chip select is low. The second, when sample/hold control is enabled, is a rising edge on an external sample input. The 2-bit channel address is captured at the write edge.

Each conversion runs a 5-clock acquisition phase and then 12 decision clocks. In those clocks the code is resolved most significant bit first from a one-bit comparator input. An active-low busy flag covers the whole conversion.

After reset the block waits out a power-up delay. It then runs a timed calibration phase, which is always followed by one automatic conversion. A calibration request aborts any conversion in progress. A power-down level parks the block in a low-power idle state. A conversion or a calibration started from there returns to power-down when it finishes.

Top module: `sar_seq_top`

## Requirements
- R1: Outside sample/hold mode, a rising edge of `wr_ni` seen at a clock edge while `cs_ni` is 0 starts a conversion when the block is idle or powered down. `ch_i` is captured into `ch_o` at that same edge.
- R2: `busy_no` is 0 for exactly 17 cycles after the start edge: 5 acquisition cycles and then 12 decision cycles. When `busy_no` returns to 1, `done_o` is 1 for exactly that one cycle.
- R3: `code_o` reads 0 in the first acquisition cycle. Each decision cycle presents a trial code with the current bit set. `cmp_i`=1 keeps that bit and `cmp_i`=0 clears it, bit 11 first. The final code therefore equals the largest value whose trials the comparator accepted.
- R4: Once busy is released, `code_o` and `ch_o` hold their values until the next start, whatever `cmp_i` does.
- R5: After reset, `busy_no`=0, `done_o`=0, `code_o`=0, `cal_o`=0 and `pdn_o`=0. `cal_o` rises after 37393 clocks. Calibration (`cal_o`=1) lasts 4608 clocks and is followed by one conversion.
- R6: A rising `cal_req_i` outside the power-up wait and outside calibration aborts any conversion and starts calibration. Busy is released 4626 clocks after the request edge: 4608 calibration clocks, 17 conversion clocks, and the edge itself.
- R7: During calibration a write strobe neither starts a conversion nor changes `ch_o`. `ch_o` also stays stable while busy.
- R8: With `sh_mode_i`=1, a rising `sh_i` starts a conversion at the next clock edge. A write strobe then only captures `ch_i` into `ch_o` and leaves `busy_no` at 1.
- R9: With `pdn_i`=1 while idle, `pdn_o`=1 after the next clock. A conversion started from power-down drops `pdn_o`. `pdn_o` returns to 1 in the cycle busy is released.
- R10: A calibration request while powered down runs calibration plus one conversion. The block re-enters power-down in the same cycle busy is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| wr_ni | input | 1 | Write strobe, active low; the rising edge acts |
| ch_i | input | 2 | Channel address |
| sh_mode_i | input | 1 | Sample/hold control mode enable |
| sh_i | input | 1 | External sample input; the rising edge starts a conversion in sample/hold mode |
| cal_req_i | input | 1 | Calibration request; the rising edge acts |
| pdn_i | input | 1 | Power-down request level |
| cmp_i | input | 1 | Comparator: 1 means input at or above trial code |
| busy_no | output | 1 | Busy, active low |
| done_o | output | 1 | One-cycle pulse when the result becomes valid |
| code_o | output | 12 | Conversion code register |
| ch_o | output | 2 | Latched channel address |
| cal_o | output | 1 | Calibration phase active |
| pdn_o | output | 1 | Powered down |

## Verification
The converter is driven by a comparator model that compares a target value against the trial code on `code_o`. The targets are zero, full scale, the two values on either side of mid-scale, an alternating pattern and 1. Together they tell apart a dropped decision, a wrong bit order and an off-by-one in the bit index. Each start is timed to the exact cycle count of busy, so that an acquisition or decision phase that is one cycle long or short shows up. Write pulses are placed inside a calibration and inside sample/hold mode. These show that only the intended source starts a conversion and latches the channel. Calibration runs from power-up, during a conversion and from power-down tell apart the timed phases and the return state.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [2:0] {
    ST_PUP,
    ST_CAL,
    ST_IDLE,
    ST_PDN,
    ST_ACQ,
    ST_CONV
  } seq_state_e;
endpackage

// File: rtl/sar_seq_edge.sv
module sar_seq_edge #(
  parameter int            W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= in_i;
  end

  assign rise_o = in_i & ~prev_q;
endmodule

// File: rtl/sar_seq_timer.sv
module sar_seq_timer #(
  parameter int            W       = 16,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= RST_VAL;
    else if (load_i)   cnt_q <= val_i;
    else if (!zero_o)  cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sar_seq_sar_reg.sv
module sar_seq_sar_reg #(
  parameter int W     = 12,
  parameter int IDX_W = $clog2(W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             msb_i,
  input  logic             step_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             cmp_i,
  output logic [W-1:0]     code_o
);
  logic [W-1:0] code_q, code_d;

  always_comb begin
    code_d = code_q;
    if (clr_i) begin
      code_d = '0;
    end else if (msb_i) begin
      code_d[W-1] = 1'b1;
    end else if (step_i) begin
      for (int i = 0; i < W; i++) begin
        if (IDX_W'(i) == idx_i) code_d[i] = cmp_i;
        // next lower bit becomes the new trial
        if ((i < W - 1) && (IDX_W'(i + 1) == idx_i)) code_d[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= '0;
    else         code_q <= code_d;
  end

  assign code_o = code_q;
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS   = 12,
  parameter int CH_W       = 2,
  parameter int ACQ_CLKS   = 5,
  parameter int CAL_CLKS   = 4608,
  parameter int PWRUP_CLKS = 37393
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_ni,
  input  logic                wr_ni,
  input  logic [CH_W-1:0]     ch_i,
  input  logic                sh_mode_i,
  input  logic                sh_i,
  input  logic                cal_req_i,
  input  logic                pdn_i,
  input  logic                cmp_i,
  output logic                busy_no,
  output logic                done_o,
  output logic [RES_BITS-1:0] code_o,
  output logic [CH_W-1:0]     ch_o,
  output logic                cal_o,
  output logic                pdn_o
);
  localparam int MAX_CLKS = (PWRUP_CLKS > CAL_CLKS) ? PWRUP_CLKS : CAL_CLKS;
  localparam int CNT_W    = $clog2(MAX_CLKS);
  localparam int IDX_W    = $clog2(RES_BITS);
  localparam logic [CNT_W-1:0] PUP_LD = CNT_W'(PWRUP_CLKS - 1);
  localparam logic [CNT_W-1:0] CAL_LD = CNT_W'(CAL_CLKS - 1);
  localparam logic [CNT_W-1:0] ACQ_LD = CNT_W'(ACQ_CLKS - 1);
  localparam logic [CNT_W-1:0] RES_LD = CNT_W'(RES_BITS - 1);

  seq_state_e        state_q, state_d;
  logic [2:0]        rise;
  logic              wr_rise, sh_rise, cal_rise;
  logic              idle, start, ch_load, cal_go;
  logic              tmr_load, tmr_zero;
  logic [CNT_W-1:0]  tmr_val, tmr_cnt;
  logic              sar_clr, sar_msb, sar_step;
  logic              done_d, done_q;
  logic [CH_W-1:0]   ch_q;

  sar_seq_edge #(
    .W       (3),
    .RST_VAL (3'b001)
  ) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   ({cal_req_i, sh_i, wr_ni}),
    .rise_o (rise)
  );

  assign wr_rise  = rise[0] & ~cs_ni;
  assign sh_rise  = rise[1];
  assign cal_rise = rise[2];

  assign idle    = (state_q == ST_IDLE) || (state_q == ST_PDN);
  assign start   = idle && (sh_mode_i ? sh_rise : wr_rise);
  assign ch_load = idle && wr_rise;
  assign cal_go  = cal_rise && (state_q != ST_PUP) && (state_q != ST_CAL);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sar_clr  = 1'b0;
    sar_msb  = 1'b0;
    sar_step = 1'b0;
    done_d   = 1'b0;
    if (cal_go) begin
      state_d  = ST_CAL;
      tmr_load = 1'b1;
      tmr_val  = CAL_LD;
    end else begin
      unique case (state_q)
        ST_PUP: if (tmr_zero) begin
          state_d  = ST_CAL;
          tmr_load = 1'b1;
          tmr_val  = CAL_LD;
        end
        ST_CAL: if (tmr_zero) begin
          state_d  = ST_ACQ;
          tmr_load = 1'b1;
          tmr_val  = ACQ_LD;
          sar_clr  = 1'b1;
        end
        ST_ACQ: if (tmr_zero) begin
          state_d  = ST_CONV;
          tmr_load = 1'b1;
          tmr_val  = RES_LD;
          sar_msb  = 1'b1;
        end
        ST_CONV: begin
          sar_step = 1'b1;
          if (tmr_zero) begin
            state_d = pdn_i ? ST_PDN : ST_IDLE;
            done_d  = 1'b1;
          end
        end
        ST_IDLE, ST_PDN: begin
          if (start) begin
            state_d  = ST_ACQ;
            tmr_load = 1'b1;
            tmr_val  = ACQ_LD;
            sar_clr  = 1'b1;
          end else if (pdn_i) begin
            state_d = ST_PDN;
          end else begin
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PUP;
      done_q  <= 1'b0;
      ch_q    <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (ch_load && !cal_go) ch_q <= ch_i;
    end
  end

  sar_seq_timer #(
    .W       (CNT_W),
    .RST_VAL (PUP_LD)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .cnt_o  (tmr_cnt),
    .zero_o (tmr_zero)
  );

  sar_seq_sar_reg #(
    .W     (RES_BITS),
    .IDX_W (IDX_W)
  ) u_sar (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sar_clr),
    .msb_i  (sar_msb),
    .step_i (sar_step),
    .idx_i  (tmr_cnt[IDX_W-1:0]),
    .cmp_i  (cmp_i),
    .code_o (code_o)
  );

  assign busy_no = idle;
  assign done_o  = done_q;
  assign ch_o    = ch_q;
  assign cal_o   = (state_q == ST_CAL);
  assign pdn_o   = (state_q == ST_PDN);
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int RES_BITS = 12,
  parameter int CH_W     = 2,
  parameter int CAL_CLKS = 4608
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                busy_no,
  input logic                done_o,
  input logic [RES_BITS-1:0] code_o,
  input logic [CH_W-1:0]     ch_o,
  input logic                cal_o,
  input logic                pdn_o
);
  localparam int RUN_W = $clog2(CAL_CLKS + 1) + 1;
  logic [RUN_W-1:0] cal_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cal_run_q <= '0;
    else if (cal_o) cal_run_q <= cal_run_q + 1'b1;
    else            cal_run_q <= '0;
  end

  a_r2_done_on_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (busy_no && !$past(busy_no)));

  a_r2_release_gives_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_no) |-> done_o);

  a_r4_code_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_no && $past(busy_no)) |-> $stable(code_o));

  a_r5_cal_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cal_o) |-> (cal_run_q == RUN_W'(CAL_CLKS)));

  a_r6_cal_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_o |-> !busy_no);

  a_r7_ch_hold_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_no && !$past(busy_no)) |-> $stable(ch_o));

  a_r9_pdn_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdn_o |-> (busy_no && !cal_o));
endmodule

bind sar_seq_top sar_seq_chk #(
  .RES_BITS (RES_BITS),
  .CH_W     (CH_W),
  .CAL_CLKS (CAL_CLKS)
) u_chk (.*);

// File: tb/sar_seq_top_tb_top.sv
module sar_seq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CAL_N      = 4608;
  localparam int PUP_N      = 37393;
  localparam int CONV_N     = 18;  // start edge plus 17 busy cycles
  localparam logic [13:0] VEC [6] = '{
    {2'd0, 12'h000}, {2'd1, 12'hFFF}, {2'd2, 12'h800},
    {2'd3, 12'h7FF}, {2'd1, 12'hA5A}, {2'd2, 12'h001}
  };

  logic        clk = 1'b0;
  logic        rst_ni, cs_ni, wr_ni, sh_mode_i, sh_i, cal_req_i, pdn_i, cmp_i;
  logic [1:0]  ch_i;
  logic        busy_no, done_o, cal_o, pdn_o;
  logic [11:0] code_o, ch_o_w;
  logic [1:0]  ch_o;
  logic [11:0] tgt;
  int          checks = 0, fails = 0;
  bit          finished = 0;

  assign ch_o_w = {10'd0, ch_o};

  always #(CLK_PERIOD / 2) clk = ~clk;

  sar_seq_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .wr_ni(wr_ni), .ch_i(ch_i),
    .sh_mode_i(sh_mode_i), .sh_i(sh_i), .cal_req_i(cal_req_i), .pdn_i(pdn_i),
    .cmp_i(cmp_i), .busy_no(busy_no), .done_o(done_o), .code_o(code_o),
    .ch_o(ch_o), .cal_o(cal_o), .pdn_o(pdn_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // run until busy is released; comparator model answers trial codes on code_o
  task automatic run_busy(input int poke_at, input logic [1:0] poke_ch, output int n,
                          output logic [11:0] f_code, output logic f_pdn, output logic f_busy);
    n = 0; f_code = '0; f_pdn = 1'b0; f_busy = 1'b1;
    do begin
      @(negedge clk);
      n++;
      cmp_i = (tgt >= code_o);
      if (n == 1) begin
        cal_req_i = 1'b0;
        f_code = code_o; f_pdn = pdn_o; f_busy = busy_no;
      end
      if (n == poke_at) begin wr_ni = 1'b0; ch_i = poke_ch; end
      if (n == poke_at + 2) wr_ni = 1'b1;
    end while (!busy_no && n < 60000);
  endtask

  task automatic wr_pulse(input logic [1:0] ch);
    @(negedge clk); cs_ni = 1'b0; wr_ni = 1'b0; ch_i = ch;
    @(negedge clk); wr_ni = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    logic [11:0] fc;
    logic fp, fb, done_prev;
    logic [11:0] held;
    rst_ni = 0; cs_ni = 1; wr_ni = 1; ch_i = 0; sh_mode_i = 0; sh_i = 0;
    cal_req_i = 0; pdn_i = 0; cmp_i = 0; tgt = 12'h3C5;
    repeat (3) @(negedge clk);
    // R5 reset state
    chk(busy_no == 0 && done_o == 0 && code_o == 0 && cal_o == 0 && pdn_o == 0,
        "R5 reset", {busy_no, done_o, cal_o, pdn_o}, 0);
    rst_ni = 1;
    n = 0;
    do begin @(negedge clk); n++; end while (!cal_o && n < 60000);
    chk(n == PUP_N, "R5 power-up delay", n, PUP_N);
    run_busy(0, 2'd0, n, fc, fp, fb);
    chk(n == CAL_N + 17, "R5 cal plus conversion", n, CAL_N + 17);
    chk(code_o == 12'h3C5, "R5 auto conversion code", code_o, 12'h3C5);
    chk(done_o == 1, "R2 done after cal", done_o, 1);

    // R1 R2 R3 vector table
    foreach (VEC[i]) begin
      tgt = VEC[i][11:0];
      wr_pulse(VEC[i][13:12]);
      run_busy(0, 2'd0, n, fc, fp, fb);
      chk(n == CONV_N, "R2 busy length", n, CONV_N);
      chk(fc == 0, "R3 code cleared at start", fc, 0);
      chk(code_o == tgt, "R3 final code", code_o, tgt);
      chk(ch_o == VEC[i][13:12], "R1 channel latched", ch_o_w, VEC[i][13:12]);
      chk(done_o == 1, "R2 done with release", done_o, 1);
      @(negedge clk);
      chk(done_o == 0, "R2 done one cycle", done_o, 0);
    end

    // R4 result held while comparator toggles
    held = code_o;
    for (int k = 0; k < 12; k++) begin @(negedge clk); cmp_i = ~cmp_i; end
    chk(code_o == held && busy_no == 1, "R4 code held", code_o, held);

    // R6 R7 abort a conversion, write during calibration ignored
    tgt = 12'h5A5;
    wr_pulse(2'd1);
    repeat (8) @(negedge clk);
    cal_req_i = 1'b1; tgt = 12'h123;
    run_busy(100, 2'd2, n, fc, fp, fb);
    chk(n == CAL_N + CONV_N, "R6 cal request timing", n, CAL_N + CONV_N);
    chk(ch_o == 2'd1, "R7 channel kept through cal", ch_o_w, 1);
    chk(code_o == 12'h123, "R6 code after cal", code_o, 12'h123);
    chk(done_o == 1, "R6 done after cal", done_o, 1);

    // R9 power-down
    @(negedge clk); pdn_i = 1'b1;
    @(negedge clk);
    chk(pdn_o == 1 && busy_no == 1, "R9 enter power-down", pdn_o, 1);
    tgt = 12'h9C3;
    wr_pulse(2'd3);
    run_busy(0, 2'd0, n, fc, fp, fb);
    chk(fp == 0, "R9 awake during conversion", fp, 0);
    chk(n == CONV_N && code_o == 12'h9C3, "R9 conversion from power-down", code_o, 12'h9C3);
    chk(pdn_o == 1, "R9 back to power-down", pdn_o, 1);

    // R10 calibration from power-down
    @(negedge clk); cal_req_i = 1'b1; tgt = 12'h2B7;
    run_busy(0, 2'd0, n, fc, fp, fb);
    chk(n == CAL_N + CONV_N, "R10 cal in power-down timing", n, CAL_N + CONV_N);
    chk(pdn_o == 1 && done_o == 1, "R10 returns to power-down", {pdn_o, done_o}, 3);
    @(negedge clk); pdn_i = 1'b0;
    @(negedge clk);
    chk(pdn_o == 0, "R9 leave power-down", pdn_o, 0);

    // R8 sample/hold mode
    sh_mode_i = 1'b1;
    wr_pulse(2'd2);
    done_prev = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (!busy_no) done_prev = 1'b1;
    end
    chk(done_prev == 0, "R8 write does not start", done_prev, 0);
    chk(ch_o == 2'd2, "R8 write latches channel", ch_o_w, 2);
    tgt = 12'hE01;
    @(negedge clk); sh_i = 1'b1;
    run_busy(0, 2'd0, n, fc, fp, fb);
    chk(fb == 0, "R8 start within one clock", fb, 0);
    chk(n == CONV_N && code_o == 12'hE01, "R8 sample edge conversion", code_o, 12'hE01);
    chk(ch_o == 2'd2, "R8 channel unchanged", ch_o_w, 2);
    sh_i = 1'b0;
    @(negedge clk);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule